// File: doc/BRIEF.md
# Daisy-Chainable Serial DAC Loader

This block is the synchronous three-wire front end of a 16-bit output converter. A host presents serial data together with a shift clock and a latch strobe. Each rising shift-clock edge moves one bit into a 16-bit input register, most significant bit first. A rising edge on the latch strobe then copies the whole input register at once into the DAC code register. That register drives the converter core through a parallel 16-bit output.

The serial output carries each bit as it leaves the top of the input register. It changes after a falling shift-clock edge, so the next device in a chain can take it on the following rising edge. Two chained devices then act as one 32-bit shift register. A high level on the clear input forces the DAC code to the bottom of the selected range without waiting for a clock. The code stays at that value after clear is released, until the next latch. Clear leaves the input register alone.

All three serial inputs are oversampled in the system clock domain through two-flop synchronizers. The edges are found there, so the shift clock and the latch strobe must each stay at one level for at least three system clock cycles.

Top module: `dac_chain_loader`

## Requirements
- R1: On each rising edge of `sclk_i`, the input register shifts one place toward its MSB and takes `sdi_i` into bit 0. After 16 edges, the first bit sent (D15) sits in bit 15 and the last (D0) in bit 0.
- R2: A rising edge of `latch_i` copies the input register into `code_o`. `code_o` does not change on shift-clock activity or at any other time without a latch edge, clear or reset.
- R3: `sdo_o` updates only after a falling edge of `sclk_i`. It then shows the current bit 15 of the input register, which is the bit the next rising edge will push out. A word shifted in is therefore seen on `sdo_o` MSB first during the next 16 shifts.
- R4: With `sdo_o` of a near device wired to `sdi_i` of a far device, 32 shifted bits leave the first 16 in the far device and the last 16 in the near device.
- R5: While `clr_i` is high, `code_o` equals the range floor. It takes that value at once when `clr_i` rises, without waiting for a clock edge. After `clr_i` falls, `code_o` keeps that value until the next latch edge.
- R6: Clear does not alter the input register. A latch after a clear, with no shifting in between, delivers the word that was shifted in before the clear.
- R7: `rst_n` is a synchronous active-low reset. After it, `code_o` is the range floor, the input register is all zero and `sdo_o` is 0.
- R8: The range floor is selected by `range_i`. Code 00 (live-zero 4–20 mA on a 0–24 mA scale) gives 0x2AAB, which is round(2^16/6). Codes 01 (0–20 mA), 10 (0–24 mA) and 11 (0–5 V) give 0x0000. While clear is held, a change of `range_i` reaches `code_o` within one system clock.
- R9: Each latch rising edge loads exactly once. If the latch strobe is held high while more bits are shifted, `code_o` does not change again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock; data is taken on its rising edge |
| sdi_i | input | 1 | Serial data in, MSB first |
| latch_i | input | 1 | Latch strobe; a rising edge loads the DAC code |
| clr_i | input | 1 | Asynchronous active-high clear to the range floor |
| range_i | input | 2 | Output range select, which sets the floor code |
| sdo_o | output | 1 | Serial data out for the next device in a chain |
| code_o | output | 16 | Parallel DAC code to the converter core |

## Verification
A wrong bit in the input register does not show on `code_o` until the next latch edge. Before that, it shows on `sdo_o` after at most 16 falling shift-clock edges, at the moment the bit reaches the top of the register. The bench therefore checks the serial output bit by bit on every shift, and it checks the latched code after each word. A chained second device turns any slip in `sdo_o` timing into a visibly wrong far-device code. Clear paths are checked a fraction of a cycle after `clr_i` rises, because a late or missing floor value would otherwise appear only at the next clock.

// File: rtl/dcl_pkg.sv
// dcl_pkg: shared types and helpers for the serial DAC loader.
// Assumes codes are at most 31 bits wide so the floor arithmetic fits an int.
package dcl_pkg;

    // Output range selector; the encoding is fixed by the range_i port.
    typedef enum logic [1:0] {
        RNG_LIVE_ZERO = 2'b00,   // 4-20 mA on a 0-24 mA scale
        RNG_ZERO_20   = 2'b01,   // 0-20 mA
        RNG_ZERO_24   = 2'b10,   // 0-24 mA over-range
        RNG_VOLT      = 2'b11    // 0-5 V
    } range_e;

    // Bottom-of-range code for a given selector and code width.
    function automatic logic [31:0] floor_code(input logic [1:0] sel, input int width);
        logic [31:0] live_zero;
        live_zero = 32'(((64'd1 << width) + 64'd3) / 64'd6);
        case (range_e'(sel))
            RNG_LIVE_ZERO: floor_code = live_zero;
            default:       floor_code = 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/dcl_sync.sv
// dcl_sync: bank of multi-stage synchronizers, one per input bit.
// Assumes each input is a level that stays put for longer than STAGES clocks.
module dcl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Stage s: takes the raw input (s == 0) or the previous stage.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    stage_q[s] <= '0;
                end else begin
                    if (s == 0) begin
                        stage_q[s] <= async_i;
                    end else begin
                        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                    end
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dcl_edge.sv
// dcl_edge: one-cycle rise and fall pulses from a synchronized level.
// Assumes the input is already in the clk_i domain.
module dcl_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic prev_q;

    // Remember last cycle's level for edge comparison.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_i;
        end
    end

    assign rise_o = level_i & ~prev_q;
    assign fall_o = ~level_i & prev_q;

    // R9: an edge yields a single-cycle pulse, never a held level.
    p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

    p_single_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |=> !fall_o);

endmodule

// File: rtl/dcl_shift.sv
// dcl_shift: input shift register and registered chain output.
// Shifts MSB-first on shift_i; sdo_o follows the top bit on fall_i so the
// next device sees the bit that the next shift will push out.
module dcl_shift #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              shift_i,
    input  logic              fall_i,
    input  logic              sdi_i,
    output logic [DATA_W-1:0] shreg_o,
    output logic              sdo_o
);

    logic [DATA_W-1:0] shreg_q;
    logic              sdo_q;

    // Shift one bit in at the bottom on each shift pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            shreg_q <= '0;
        end else if (shift_i) begin
            shreg_q <= {shreg_q[DATA_W-2:0], sdi_i};
        end
    end

    // Present the outgoing bit after each falling shift-clock edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sdo_q <= 1'b0;
        end else if (fall_i) begin
            sdo_q <= shreg_q[DATA_W-1];
        end
    end

    assign shreg_o = shreg_q;
    assign sdo_o   = sdo_q;

    // R1: without a shift pulse the register holds.
    p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !shift_i |=> $stable(shreg_q));

    // R1: the sampled data bit lands in bit 0.
    p_lsb_in_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |=> shreg_q[0] == $past(sdi_i));

    // R3: the chain output moves only after a falling edge.
    p_sdo_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fall_i |=> $stable(sdo_q));

    // R7: reset empties the register and the chain output.
    p_reset_clear_r7: assert property (@(posedge clk_i)
        !rst_ni |=> (shreg_q == '0) && !sdo_q);

endmodule

// File: rtl/dcl_code.sv
// dcl_code: DAC code register with parallel load and asynchronous clear.
// Clear and reset both force the floor of the selected range; the clear
// acts without a clock and re-reads range_i on every clock while held.
module dcl_code #(
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic [1:0]        range_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] shreg_i,
    output logic [DATA_W-1:0] code_o
);

    import dcl_pkg::*;

    logic [DATA_W-1:0] floor_w;
    logic [31:0]       floor_full;
    logic [DATA_W-1:0] code_q;

    // Floor value for the current range selection.
    always_comb begin
        floor_full = floor_code(range_i, DATA_W);
        floor_w    = floor_full[DATA_W-1:0];
    end

    // Code register: clear wins, then reset, then a latch load.
    always_ff @(posedge clk_i or posedge clr_i) begin
        if (clr_i) begin
            code_q <= floor_w;
        end else if (!rst_ni) begin
            code_q <= floor_w;
        end else if (load_i) begin
            code_q <= shreg_i;
        end
    end

    assign code_o = code_q;

    // R2: a load pulse transfers the input register.
    p_load_copy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        load_i |=> code_q == $past(shreg_i));

    // R2: no load, no change.
    p_code_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
        !load_i |=> $stable(code_q));

    // R5: a held clear keeps the floor of an unchanged range.
    p_clear_floor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && $stable(range_i)) |-> code_q == floor_w);

    // R7: reset leaves the floor of the range seen at reset.
    p_reset_floor_r7: assert property (@(posedge clk_i) disable iff (clr_i)
        !rst_ni |=> code_q == $past(floor_w));

endmodule

// File: rtl/dac_chain_loader.sv
// dac_chain_loader: three-wire serial loader for a 16-bit DAC code, with
// chain output, latch transfer and clear to the range floor.
// Assumes sclk_i and latch_i each hold a level for at least three clk cycles.
module dac_chain_loader #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              latch_i,
    input  logic              clr_i,
    input  logic [1:0]        range_i,
    output logic              sdo_o,
    output logic [DATA_W-1:0] code_o
);

    localparam int N_SYNC = 3;
    localparam int IX_SCLK  = 0;
    localparam int IX_SDI   = 1;
    localparam int IX_LATCH = 2;

    logic [N_SYNC-1:0] raw_w;
    logic [N_SYNC-1:0] syn_w;
    logic              shift_w;
    logic              sfall_w;
    logic              load_w;
    logic              lfall_w;
    logic [DATA_W-1:0] shreg_w;

    // Gather the serial inputs into one synchronizer bank.
    always_comb begin
        raw_w           = '0;
        raw_w[IX_SCLK]  = sclk_i;
        raw_w[IX_SDI]   = sdi_i;
        raw_w[IX_LATCH] = latch_i;
    end

    dcl_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .async_i (raw_w),
        .sync_o  (syn_w)
    );

    dcl_edge u_sclk_edge (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .level_i (syn_w[IX_SCLK]),
        .rise_o  (shift_w),
        .fall_o  (sfall_w)
    );

    dcl_edge u_latch_edge (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .level_i (syn_w[IX_LATCH]),
        .rise_o  (load_w),
        .fall_o  (lfall_w)
    );

    dcl_shift #(.DATA_W(DATA_W)) u_shift (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .shift_i (shift_w),
        .fall_i  (sfall_w),
        .sdi_i   (syn_w[IX_SDI]),
        .shreg_o (shreg_w),
        .sdo_o   (sdo_o)
    );

    dcl_code #(.DATA_W(DATA_W)) u_code (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .clr_i   (clr_i),
        .range_i (range_i),
        .load_i  (load_w),
        .shreg_i (shreg_w),
        .code_o  (code_o)
    );

    // R6: clear never disturbs the input register.
    p_clear_keeps_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !shift_w) |=> $stable(shreg_w));

    // R9: latch falling edge never loads.
    p_latch_fall_inert_r9: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
        lfall_w |=> $stable(code_o));

endmodule

// File: tb/dac_chain_loader_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module dac_chain_loader_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        latch = 1'b0;
    logic        clr = 1'b0;
    logic [1:0]  rng = 2'b00;
    logic        sdo_near;
    logic        sdo_far;
    logic [15:0] code_near;
    logic [15:0] code_far;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [15:0] sdo_seen;

    localparam logic [15:0] LIVE_ZERO = 16'h2AAB;

    always #2 clk = ~clk;   // 250 MHz

    dac_chain_loader dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi),
        .latch_i(latch), .clr_i(clr), .range_i(rng),
        .sdo_o(sdo_near), .code_o(code_near)
    );

    dac_chain_loader dut_far_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdo_near),
        .latch_i(latch), .clr_i(clr), .range_i(rng),
        .sdo_o(sdo_far), .code_o(code_far)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit; records sdo just before the rising edge.
    task automatic shift_bit(input logic b);
        sdi = b;
        wait_clk(4);
        sdo_seen = {sdo_seen[14:0], sdo_near};
        sclk = 1'b1;
        wait_clk(8);
        sclk = 1'b0;
        wait_clk(8);
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_latch();
        latch = 1'b1;
        wait_clk(8);
        latch = 1'b0;
        wait_clk(8);
    endtask

    task automatic do_reset(input logic [1:0] r);
        rng = r;
        rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
    endtask

    task automatic t_reset();
        do_reset(2'b00);
        check("R7 reset code floor", code_near, LIVE_ZERO);
        check("R7 reset sdo", {15'd0, sdo_near}, 16'h0000);
        pulse_latch();
        check("R7 reset shift register zero", code_near, 16'h0000);
    endtask

    task automatic t_load_and_hold();
        shift_word(16'hA5C3);
        check("R2 no change before latch", code_near, 16'h0000);
        pulse_latch();
        check("R1 R2 latched word A5C3", code_near, 16'hA5C3);
        shift_word(16'h1234);
        check("R2 hold during shifting", code_near, 16'hA5C3);
        check("R3 sdo carried previous word MSB first", sdo_seen, 16'hA5C3);
        pulse_latch();
        check("R1 second word", code_near, 16'h1234);
        check("R4 far device holds first word", code_far, 16'hA5C3);
    endtask

    task automatic t_chain32();
        shift_word(16'h0FF1);
        shift_word(16'hC00D);
        pulse_latch();
        check("R4 near holds last 16", code_near, 16'hC00D);
        check("R4 far holds first 16", code_far, 16'h0FF1);
    endtask

    task automatic t_clear();
        shift_word(16'h5A5A);
        pulse_latch();
        shift_word(16'h3C96);
        rng = 2'b00;
        wait_clk(2);
        clr = 1'b1;
        #1;
        check("R5 async clear to floor", code_near, LIVE_ZERO);
        wait_clk(2);
        rng = 2'b01;
        wait_clk(2);
        check("R8 range 01 floor during clear", code_near, 16'h0000);
        rng = 2'b00;
        wait_clk(2);
        check("R8 range 00 floor during clear", code_near, LIVE_ZERO);
        clr = 1'b0;
        wait_clk(20);
        check("R5 floor held after release", code_near, LIVE_ZERO);
        pulse_latch();
        check("R6 shift register survived clear", code_near, 16'h3C96);
    endtask

    task automatic t_ranges();
        do_reset(2'b10);
        check("R8 range 10 reset floor", code_near, 16'h0000);
        shift_word(16'hFFFF);
        pulse_latch();
        rng = 2'b11;
        wait_clk(1);
        clr = 1'b1;
        #1;
        check("R8 range 11 clear floor", code_near, 16'h0000);
        wait_clk(2);
        clr = 1'b0;
        wait_clk(2);
        rng = 2'b00;
        wait_clk(2);
        check("R5 floor kept after range change", code_near, 16'h0000);
    endtask

    task automatic t_latch_once();
        shift_word(16'h7E81);
        latch = 1'b1;
        wait_clk(8);
        check("R9 load on latch rise", code_near, 16'h7E81);
        shift_word(16'h0420);
        check("R9 no reload while latch held", code_near, 16'h7E81);
        latch = 1'b0;
        wait_clk(8);
        check("R9 no load on latch fall", code_near, 16'h7E81);
        pulse_latch();
        check("R9 next rise loads", code_near, 16'h0420);
    endtask

    initial begin
        t_reset();
        t_load_and_hold();
        t_chain32();
        t_clear();
        t_ranges();
        t_latch_once();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule